// File: doc/BRIEF.md
# Cache Sleep Mode Controller

This block controls entry into and exit from a low-power retention state for a look-aside secondary cache. A power-down request arrives asynchronously and passes through a synchronizer. The block waits until both the address bus and the data bus report idle, then enters sleep. In sleep it drops the internal clock enable and the ready indication, and the cache contents are retained.

When the request is withdrawn, the block wakes in one of two ways. A configuration strap is sampled once after hard reset and selects the way. With the strap high, the block asks an external invalidation engine to clear every tag and waits for that engine to report completion. With the strap low, the entries are kept, and bus participation is held off for a settling interval of about two microseconds. The length of that interval is computed from the clock frequency parameter.

Top module: `cache_sleep_ctrl`

## Requirements
- R1: While rst_ni is low, and from any state, the outputs take their active values at once (asynchronous reset): sleep_o=0, clk_en_o=1, ready_o=1, inval_start_o=0.
- R2: pwr_dn_req_i passes through SYNC_STAGES flops. With the default of 2, a change that is driven before clock edge k takes effect on the state at edge k+3. From a request rise, sleep_o first goes high at edge k+4, and only if addr_idle_i and data_idle_i are both high at that edge.
- R3: In sleep, sleep_o=1, clk_en_o=0, ready_o=0 and inval_start_o=0.
- R4: While the block waits for idle buses, ready_o=1 and clk_en_o=1.
- R5: If the synchronized request drops before both buses are idle, the block returns to active without ever asserting sleep_o.
- R6: strap_inval_i is sampled at the first rising clock edge after rst_ni goes high. Later changes have no effect until the next reset.
- R7: With the sampled strap at 1, a wake drives inval_start_o=1 and ready_o=0 until inval_done_i is seen high at a clock edge. From that edge on, ready_o=1 and inval_start_o=0.
- R8: With the sampled strap at 0, a wake keeps ready_o=0 for exactly HOLD_CYCLES = CLK_MHZ*HOLD_NS/1000 cycles (500 by default), and inval_start_o stays 0.
- R9: A request that rises again during a wake sequence does not shorten it. After the sequence ends, the block passes through active and resumes the entry path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hard reset |
| pwr_dn_req_i | input | 1 | Asynchronous power-down request |
| strap_inval_i | input | 1 | Wake mode strap: 1 invalidates all entries, 0 retains them |
| addr_idle_i | input | 1 | Address bus is idle |
| data_idle_i | input | 1 | Data bus is idle |
| inval_done_i | input | 1 | Invalidation engine has finished |
| sleep_o | output | 1 | Block is in the retention state |
| clk_en_o | output | 1 | Enable for the internal clock network |
| ready_o | output | 1 | Cache may take part in bus transactions |
| inval_start_o | output | 1 | Invalidation request, held until done |

## Verification
The hardest situation to reach is a request that rises again partway through a retain-mode wake. The settling counter is already running at that point, and it must neither restart nor end early. The stimulus sleeps in retain mode, drops the request, and raises it again a few cycles into the hold-off. The scoreboard then expects ready at the exact terminal cycle, followed by a fresh trip through waiting and into sleep. A separate sequence drops the request while one bus is still busy, to check that sleep is never reached on that path.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_WAIT_IDLE,
    ST_SLEEP,
    ST_WAKE_INVAL,
    ST_WAKE_HOLD
  } csc_state_e;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/csc_hold_timer.sv
module csc_hold_timer #(
  parameter int CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || done_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/csc_strap_latch.sv
module csc_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic strap_o
);
  logic armed_q;

  // capture once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      strap_o <= 1'b0;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      strap_o <= strap_i;
    end
  end

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(strap_o)); // R6
endmodule

// File: rtl/cache_sleep_ctrl.sv
module cache_sleep_ctrl
  import csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_MHZ     = 250,
  parameter int HOLD_NS     = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_dn_req_i,
  input  logic strap_inval_i,
  input  logic addr_idle_i,
  input  logic data_idle_i,
  input  logic inval_done_i,
  output logic sleep_o,
  output logic clk_en_o,
  output logic ready_o,
  output logic inval_start_o
);
  localparam int HOLD_CYCLES = (CLK_MHZ * HOLD_NS) / 1000;

  csc_state_e state_q, state_d;
  logic req_s, strap_q, hold_done, buses_idle;

  csc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwr_dn_req_i), .q_o(req_s)
  );

  csc_strap_latch u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_inval_i), .strap_o(strap_q)
  );

  csc_hold_timer #(.CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(state_q == ST_WAKE_HOLD), .done_o(hold_done)
  );

  assign buses_idle = addr_idle_i && data_idle_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE:     if (req_s) state_d = ST_WAIT_IDLE;
      ST_WAIT_IDLE:  if (!req_s)          state_d = ST_ACTIVE;
                     else if (buses_idle) state_d = ST_SLEEP;
      ST_SLEEP:      if (!req_s) state_d = strap_q ? ST_WAKE_INVAL : ST_WAKE_HOLD;
      ST_WAKE_INVAL: if (inval_done_i) state_d = ST_ACTIVE;
      ST_WAKE_HOLD:  if (hold_done)    state_d = ST_ACTIVE;
      default:       state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  assign sleep_o       = (state_q == ST_SLEEP);
  assign clk_en_o      = (state_q != ST_SLEEP);
  assign ready_o       = (state_q == ST_ACTIVE) || (state_q == ST_WAIT_IDLE);
  assign inval_start_o = (state_q == ST_WAKE_INVAL);

  AST_SLEEP_ON_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> $past(buses_idle && req_s)); // R2
  AST_WAKE_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> !$past(req_s)); // R2
  AST_RETAIN_NO_INVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_start_o |-> strap_q); // R8
  AST_INVAL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_start_o && !inval_done_i |=> inval_start_o); // R7
  AST_HOLD_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE_HOLD) && !hold_done |=> !ready_o); // R9
endmodule

// File: tb/cache_sleep_ctrl_test.sv
module cache_sleep_ctrl_test;
  localparam int H = 500;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, strap = 1'b0, a_idle = 1'b1, d_idle = 1'b1, done = 1'b0;
  logic sleep_o, clk_en_o, ready_o, inval_start_o;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  int          q_cyc[$];
  logic [3:0]  q_val[$];
  string       q_tag[$];

  cache_sleep_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_dn_req_i(req), .strap_inval_i(strap),
    .addr_idle_i(a_idle), .data_idle_i(d_idle), .inval_done_i(done),
    .sleep_o(sleep_o), .clk_en_o(clk_en_o), .ready_o(ready_o),
    .inval_start_o(inval_start_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] outs();
    return {sleep_o, clk_en_o, ready_o, inval_start_o};
  endfunction

  task automatic compare(string tag, logic [3:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d act {sleep,clk_en,ready,start}=%b exp=%b", tag, cyc, outs(), exp);
    end
  endtask

  // driver side: queue an expectation
  task automatic expect_at(int c, string tag, logic [3:0] v);
    q_cyc.push_back(c); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      if (q_cyc[0] < cyc) begin
        n_chk++; n_bad++;
        $display("FAIL %s missed cyc act=none exp=cyc %0d", q_tag[0], q_cyc[0]);
      end else compare(q_tag[0], q_val[0]);
      void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q_cyc.size() > 0) @(negedge clk);
  endtask

  localparam logic [3:0] ACT = 4'b0110, SLP = 4'b1000, HLD = 4'b0100, INV = 4'b0101;

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    // R1 reset values, strap 0 (retain)
    strap = 1'b0;
    step(2);
    compare("R1 reset", ACT);
    rst_ni = 1'b1;
    step(2);
    compare("R1 after release", ACT);

    // entry with idle buses: R2 R3 R4
    k = cyc; req = 1'b1;
    expect_at(k+2, "R2 not yet", ACT);
    expect_at(k+3, "R4 waiting idle", ACT);
    expect_at(k+4, "R3 sleep", SLP);
    step(6);
    strap = 1'b1;  // R6 ignored after reset
    step(4);
    drain();

    // retain wake: R8 R6
    k = cyc; req = 1'b0;
    expect_at(k+2, "R3 still asleep", SLP);
    expect_at(k+3, "R8 hold start", HLD);
    expect_at(k+3+H/2, "R8 hold mid", HLD);
    expect_at(k+2+H, "R8 hold last", HLD);
    expect_at(k+3+H, "R8 ready after hold", ACT);
    drain();
    step(3);

    // abort while busy: R5
    a_idle = 1'b0;
    k = cyc; req = 1'b1;
    expect_at(k+3, "R5 waiting", ACT);
    expect_at(k+4, "R5 no sleep busy", ACT);
    step(5);
    k = cyc; req = 1'b0;
    expect_at(k+1, "R5 no sleep busy2", ACT);
    expect_at(k+3, "R5 back active", ACT);
    expect_at(k+5, "R5 stays active", ACT);
    drain();
    step(2);

    // idle arrives late: R2
    k = cyc; req = 1'b1;
    expect_at(k+6, "R2 held by busy bus", ACT);
    step(8);
    k = cyc; a_idle = 1'b1;
    expect_at(k, "R2 busy still awake", ACT);
    expect_at(k+1, "R2 sleep on idle", SLP);
    drain();
    step(3);

    // request returns during hold: R9
    k = cyc; req = 1'b0;
    expect_at(k+3, "R9 hold begins", HLD);
    step(10);
    req = 1'b1;
    expect_at(k+2+H, "R9 hold not shortened", HLD);
    expect_at(k+3+H, "R9 active after hold", ACT);
    expect_at(k+4+H, "R9 waiting again", ACT);
    expect_at(k+5+H, "R9 sleep again", SLP);
    drain();
    step(2);

    // reset from sleep, strap 1: R1 R6
    rst_ni = 1'b0; req = 1'b0; strap = 1'b1;
    #1 compare("R1 async reset from sleep", ACT);
    step(2);
    rst_ni = 1'b1;
    step(1);
    strap = 1'b0;  // R6 change after sample ignored
    step(2);

    // invalidate wake: R7
    k = cyc; req = 1'b1;
    expect_at(k+4, "R3 sleep strap1", SLP);
    step(8);
    k = cyc; req = 1'b0;
    expect_at(k+3, "R7 inval start", INV);
    expect_at(k+12, "R7 held until done", INV);
    step(15);
    k = cyc; done = 1'b1;
    expect_at(k, "R7 before done edge", INV);
    expect_at(k+1, "R7 ready after done", ACT);
    step(1);
    done = 1'b0;
    drain();
    step(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule